// File: doc/BRIEF.md
# Mirror Signal Generator with Hold Tracking

This block watches a stream of signed samples of a tracking-error style waveform and raises a one-bit mirror flag while the waveform's envelope is wide. It keeps a peak-hold register that jumps up to any higher sample and slowly decays. It also keeps a bottom-hold register that jumps down to any lower sample and slowly climbs back. The envelope width is the peak minus the bottom. It is compared against a programmable level.

The flag is not raised as soon as the comparison passes. The comparison must first have held on every clock for a programmable minimum time, so short spikes are masked. A failing comparison clears the flag at once and restarts the timing. The upward creep rate of the bottom hold can be selected. A fast override forces the highest rate.

Top module: `mirror_detect`

## Requirements
- R1: A synchronous active-high reset clears `mirror` and the timing counter. It loads the peak hold with the most negative sample value and the bottom hold with the most positive value, so the envelope starts negative.
- R2: The comparison passes on a clock when (peak hold minus bottom hold), taken as a signed difference, is strictly greater than the unsigned `cmp_lvl`.
- R3: `mirror` is set only after the comparison has passed on a run of consecutive clock edges. Any clock on which it fails restarts the run from zero.
- R4: `hold_sel` codes 0, 1, 2 and 3 require runs of 32, 64, 128 and 256 clock edges. `mirror` reads 1 right after the edge that completes the run.
- R5: On the first clock edge at which the comparison fails, `mirror` becomes 0.
- R6: On an edge with `smp_vld`, a sample above the peak hold replaces it. Otherwise the peak hold drops by one LSB every 4 clocks (one step period), never below the most negative value.
- R7: On an edge with `smp_vld`, a sample below the bottom hold replaces it.
- R8: Otherwise, once per step period, the bottom hold rises by 1, 2, 4 or 8 for `rise_sel` codes 0, 1, 2, 3, saturating at the most positive value.
- R9: When `fast_rise` is 1, the bottom hold rises by 8 per step period whatever `rise_sel` holds.
- R10: The run counter saturates and does not wrap, so a comparison that keeps passing keeps `mirror` at 1 indefinitely.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_vld | input | 1 | Sample strobe |
| smp | input | W (8) | Signed sample value |
| cmp_lvl | input | W (8) | Unsigned comparator level for the envelope |
| hold_sel | input | 2 | Minimum continuous-pass time code |
| rise_sel | input | 2 | Bottom-hold steps per step period code |
| fast_rise | input | 1 | Forces 8 steps per step period |
| mirror | output | 1 | Mirror flag |

## Verification
Directed patterns come first. Alternating full-scale samples keep the envelope wide while `cmp_lvl` is dropped from its maximum. This isolates the latency of each hold code. A one-cycle level raise in the middle of a run separates a restarting counter from one that only pauses. Sample-free stretches under each `rise_sel` code and under `fast_rise` make the envelope collapse at different speeds. This exposes the creep rate as the moment `mirror` falls. Constrained random sparse samples with random levels and codes then exercise all paths together. Every cycle is compared against a bench model of the hold and timing rules.

// File: rtl/mirror_detect.sv
module mirror_detect #(
  parameter int W         = 8,
  parameter int STEP_CLKS = 4,
  parameter int BASE_HOLD = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         smp_vld,
  input  logic [W-1:0] smp,
  input  logic [W-1:0] cmp_lvl,
  input  logic [1:0]   hold_sel,
  input  logic [1:0]   rise_sel,
  input  logic         fast_rise,
  output logic         mirror
);
  localparam int SW   = (STEP_CLKS > 1) ? $clog2(STEP_CLKS) : 1;
  localparam int RMAX = BASE_HOLD * 8;
  localparam int CW   = $clog2(RMAX + 1);
  localparam logic signed [W-1:0] S_MIN = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] S_MAX = {1'b0, {(W-1){1'b1}}};

  logic [SW-1:0]        step_q;
  logic signed [W-1:0]  peak_q, bot_q;
  logic [CW-1:0]        run_q;
  logic                 tick, cond;
  logic signed [W+1:0]  diff;
  logic signed [W:0]    bot_sum, rise_amt;
  logic [CW-1:0]        run_nx, need;
  logic signed [W-1:0]  s_smp;

  assign s_smp    = $signed(smp);
  assign tick     = (step_q == SW'(STEP_CLKS - 1));
  assign diff     = {{2{peak_q[W-1]}}, peak_q} - {{2{bot_q[W-1]}}, bot_q};
  assign cond     = diff > $signed({2'b00, cmp_lvl});
  assign rise_amt = fast_rise ? (W+1)'(8) : (W+1)'(1) << rise_sel;
  assign bot_sum  = {bot_q[W-1], bot_q} + rise_amt;
  assign run_nx   = (run_q == CW'(RMAX)) ? run_q : run_q + 1'b1;
  assign need     = CW'(BASE_HOLD) << hold_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= '0;
      peak_q <= S_MIN;
      bot_q  <= S_MAX;
      run_q  <= '0;
      mirror <= 1'b0;
    end else begin
      step_q <= tick ? '0 : step_q + 1'b1;

      if (smp_vld && s_smp > peak_q)  peak_q <= s_smp;
      else if (tick && peak_q != S_MIN) peak_q <= peak_q - 1'b1;

      if (smp_vld && s_smp < bot_q)   bot_q <= s_smp;
      else if (tick)                  bot_q <= (bot_sum > $signed({S_MAX[W-1], S_MAX})) ? S_MAX : bot_sum[W-1:0];

      run_q  <= cond ? run_nx : '0;
      mirror <= cond && (run_nx >= need);
    end
  end

  AST_DROP_ON_FAIL: assert property (@(posedge clk) disable iff (rst) !cond |=> !mirror); // R5
  AST_RISE_AFTER_PASS: assert property (@(posedge clk) disable iff (rst) !$past(rst) && $rose(mirror) |-> $past(cond)); // R3
  AST_PEAK_SLOW_DECAY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (peak_q >= $past(peak_q)) || (peak_q == $past(peak_q) - 1'b1)); // R6
  AST_BOT_NO_FALL_IDLE: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) && !$past(smp_vld) |-> bot_q >= $past(bot_q)); // R8
  AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (rst) run_q <= CW'(RMAX)); // R10
endmodule

// File: tb/mirror_detect_tb.sv
module mirror_detect_tb;
  logic clk = 1'b0, rst = 1'b1, smp_vld = 1'b0, fast_rise = 1'b0;
  logic [7:0] smp = '0, cmp_lvl = 8'hff;
  logic [1:0] hold_sel = '0, rise_sel = 2'd2;
  logic mirror;
  int total = 0, bad = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  mirror_detect u_dut (.clk, .rst, .smp_vld, .smp, .cmp_lvl, .hold_sel,
                       .rise_sel, .fast_rise, .mirror);

  int m_pk, m_bt, m_sc, m_run;
  bit m_mir;

  function automatic int sx(input logic [7:0] v);
    return int'($signed(v));
  endfunction

  always @(posedge clk) begin
    int s, pk, bt, nx, need, stp;
    bit cnd, tk;
    if (rst) begin
      m_pk = -128; m_bt = 127; m_sc = 0; m_run = 0; m_mir = 0;
    end else begin
      s = sx(smp);
      tk = (m_sc == 3);
      cnd = (m_pk - m_bt) > int'(cmp_lvl);
      stp = fast_rise ? 8 : (1 << rise_sel);
      pk = m_pk; bt = m_bt;
      if (smp_vld && s > m_pk) pk = s;
      else if (tk && m_pk > -128) pk = m_pk - 1;
      if (smp_vld && s < m_bt) bt = s;
      else if (tk) bt = (m_bt + stp > 127) ? 127 : m_bt + stp;
      nx = (m_run == 256) ? 256 : m_run + 1;
      need = 32 << hold_sel;
      m_mir = cnd && (nx >= need);
      m_run = cnd ? nx : 0;
      m_pk = pk; m_bt = bt;
      m_sc = tk ? 0 : m_sc + 1;
    end
  end

  always @(negedge clk) begin
    total++;
    if (mirror !== m_mir) begin
      bad++;
      $display("FAIL %s: mirror=%0b expected=%0b at %0t", phase, mirror, m_mir, $time);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wide_run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      smp_vld = 1'b1;
      smp = i[0] ? 8'h80 : 8'h7f;
    end
    smp_vld = 1'b0;
  endtask

  task automatic latency(input logic [1:0] code);
    int cnt, exp;
    hold_sel = code; cmp_lvl = 8'hff;
    wide_run(4);
    cnt = 0;
    @(negedge clk);
    smp_vld = 1'b1; smp = 8'h7f; cmp_lvl = 8'd0;
    while (!mirror && cnt < 600) begin
      @(negedge clk);
      cnt++;
      smp = smp == 8'h7f ? 8'h80 : 8'h7f;
    end
    exp = 32 << code;
    total++;
    if (cnt != exp) begin
      bad++;
      $display("FAIL R4: latency=%0d expected=%0d code=%0d", cnt, exp, code);
    end
    smp_vld = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: run hung, expected finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    cyc(4);
    phase = "R1";
    total++;
    if (mirror !== 1'b0) begin bad++; $display("FAIL R1: mirror=%0b expected=0", mirror); end
    rst = 1'b0; cmp_lvl = 8'd0;
    cyc(40);                                  // R1: negative envelope never passes
    phase = "R7"; cmp_lvl = 8'd50;
    @(negedge clk); smp_vld = 1'b1; smp = 8'd100;
    @(negedge clk); smp = 8'h9c;              // -100: R6 and R7 capture
    @(negedge clk); smp_vld = 1'b0;
    phase = "R2"; cyc(60);
    phase = "R3"; cmp_lvl = 8'd255; @(negedge clk); cmp_lvl = 8'd50; cyc(50);
    for (int k = 0; k < 4; k++) begin
      phase = "R4"; latency(2'(k));
    end
    phase = "R10"; hold_sel = 2'd3; cmp_lvl = 8'd10; wide_run(700);
    phase = "R5"; cmp_lvl = 8'd255; cyc(3); cmp_lvl = 8'd10;
    hold_sel = 2'd0;
    for (int r = 0; r < 4; r++) begin
      phase = "R8"; rise_sel = 2'(r); cmp_lvl = 8'd60; wide_run(4); cyc(200);
    end
    phase = "R9"; fast_rise = 1'b1; rise_sel = 2'd0; wide_run(4); cyc(150);
    fast_rise = 1'b0;
    phase = "R6"; cmp_lvl = 8'd0;
    @(negedge clk); smp_vld = 1'b1; smp = 8'h7f; @(negedge clk); smp_vld = 1'b0; cyc(1200);
    phase = "R2";
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      smp_vld = ($urandom % 8) == 0;
      smp = 8'($urandom);
      if (($urandom % 300) == 0) begin
        cmp_lvl = 8'($urandom % 160);
        hold_sel = 2'($urandom); rise_sel = 2'($urandom);
        fast_rise = ($urandom % 4) == 0;
      end
      if (($urandom % 2000) == 0) rst = 1'b1; else rst = 1'b0;
    end
    rst = 1'b0; cyc(5);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule